// File: doc/BRIEF.md
# Bus Ownership Handover Controller

This block decides, on behalf of the current bus master, when to hand the shared bus to another device and when to take it back. Other would-be masters pull a shared active-low request line; the block answers with an active-low grant. The grant promises that the bus will be freed once the transfer now under way is finished. The block then waits for the new owner to announce itself, and only then turns off the drivers for its address and strobe pads. While the block is not the owner, it holds the internal cycle sequencer still. The sequencer is reduced here to a `busy` input, which marks a transfer in progress, and a `hold` output, which stops new transfers from starting.

A parameter selects one of two arbitration schemes. In the three-wire scheme, a separate active-low acknowledge input carries ownership. In the two-wire scheme there is no acknowledge. External logic merges each device's request and acknowledge onto the one request line, so that line also serves as the ownership signal. In both schemes the request and acknowledge inputs are asynchronous. Each passes through a two-stage synchroniser before the state machine uses it.

Top module: `busarb_ctrl`

## Requirements
- R1: After reset, `bg_n` is 1, `hold` is 0 and `bus_oe` is 1.
- R2: If `br_n` goes low while the block owns the bus, `bg_n` goes low and `hold` goes high on the third rising edge after the change. `bus_oe` stays 1 at that point. `br_n` may go low whether `busy` is high or low.
- R3: While `busy` is 1 on a rising edge, `bus_oe` stays 1 after that edge.
- R4: In three-wire mode (`TWO_WIRE`=0), ownership passes on the first rising edge that meets all of these conditions: the grant is outstanding, `busy` is 0, and a low `bgack_n` has been through the synchroniser. A low `bgack_n` takes two edges to pass through. On that edge `bus_oe` goes to 0 and `bg_n` returns to 1.
- R5: In three-wire mode, if `br_n` returns high before any acknowledge arrives, the block keeps the bus. On the third edge after the change, `bg_n` goes to 1, `hold` goes to 0 and `bus_oe` stays 1.
- R6: When the other master lets go, the block takes the bus back on the third rising edge after the change. In three-wire mode letting go means `bgack_n` goes high; in two-wire mode it means `br_n` goes high. On that edge `bus_oe` goes to 1 and `hold` goes to 0.
- R7: In two-wire mode (`TWO_WIRE`=1), `bgack_n` has no effect on any output.
- R8: In two-wire mode, ownership passes on the first rising edge after the grant at which `busy` is 0 and the synchronised `br_n` is still low. If `br_n` returns high while `busy` is still 1, the block keeps the bus: on the third edge after the change `bg_n` goes to 1 and `hold` goes to 0.
- R9: Whenever `bus_oe` is 0 or `bg_n` is 0, `hold` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| br_n | input | 1 | Wire-OR bus request from other masters, active low, asynchronous |
| bgack_n | input | 1 | Ownership acknowledge from the new master, active low, asynchronous; unused in two-wire mode |
| busy | input | 1 | Internal sequencer has a bus transfer in progress |
| bg_n | output | 1 | Bus grant, active low |
| hold | output | 1 | Stops the internal sequencer from starting a transfer |
| bus_oe | output | 1 | Output enable for the address and strobe pads; 0 means high impedance |

## Verification
The three-wire instance is tried with every pairing of transfer length (0 to 6 cycles) and acknowledge arrival (3 to 5 cycles after the request). This separates a handover limited by the acknowledge from one limited by the end of the transfer. A second pattern withdraws the request at several points, with and without a transfer in progress, which shows whether the grant is cleared without losing the bus. The two-wire instance is driven with its acknowledge pin held low throughout, which exposes any use of that pin. It is also run with short and long transfers, to tell an immediate handover apart from one that waits for the transfer to end, and with a withdrawal during a long transfer.

// File: rtl/busarb_pkg.sv
`timescale 1ns/1ps
package busarb_pkg;

    localparam int unsigned ARB_SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        ARB_OWN   = 2'd0,
        ARB_GRANT = 2'd1,
        ARB_OTHER = 2'd2
    } arb_state_e;

    typedef struct packed {
        arb_state_e st;
        logic       bg_n;
        logic       hold;
        logic       oe;
    } arb_regs_t;

    localparam arb_regs_t ARB_RESET = '{st: ARB_OWN, bg_n: 1'b1, hold: 1'b0, oe: 1'b1};

endpackage

// File: rtl/busarb_sync.sv
`timescale 1ns/1ps
module busarb_sync #(
    parameter int unsigned WIDTH   = 1,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/busarb_fsm.sv
`timescale 1ns/1ps
module busarb_fsm
    import busarb_pkg::*;
#(
    parameter bit TWO_WIRE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,      // synchronised request, active high
    input  logic ack_in,   // synchronised acknowledge, active high
    input  logic busy,
    output logic bg_n,
    output logic hold,
    output logic bus_oe
);
    arb_regs_t r_d, r_q;
    logic own_sig;

    // Ownership indicator: merged request line in two-wire mode.
    assign own_sig = TWO_WIRE ? req : ack_in;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ARB_OWN:   if (req) r_d.st = ARB_GRANT;
            ARB_GRANT: begin
                if (own_sig && !busy)      r_d.st = ARB_OTHER;
                else if (!req && !own_sig) r_d.st = ARB_OWN;
            end
            ARB_OTHER: if (!own_sig) r_d.st = ARB_OWN;
            default:   r_d.st = ARB_OWN;
        endcase
        r_d.bg_n = (r_d.st != ARB_GRANT);
        r_d.hold = (r_d.st != ARB_OWN);
        r_d.oe   = (r_d.st != ARB_OTHER);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= ARB_RESET;
        else        r_q <= r_d;
    end

    assign bg_n   = r_q.bg_n;
    assign hold   = r_q.hold;
    assign bus_oe = r_q.oe;

    assert_oe_off_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.oe |-> r_q.hold);
    assert_grant_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.bg_n |-> r_q.hold);
    assert_busy_keeps_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.oe && busy) |=> r_q.oe);
    assert_release_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.oe) |-> $past(!r_q.bg_n));
    assert_reclaim_on_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.oe) |-> $past(!own_sig));
    assert_withdraw_needs_no_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(r_q.bg_n) && r_q.oe) |-> $past(!req));

endmodule

// File: rtl/busarb_ctrl.sv
`timescale 1ns/1ps
module busarb_ctrl
    import busarb_pkg::*;
#(
    parameter bit TWO_WIRE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic br_n,
    input  logic bgack_n,
    input  logic busy,
    output logic bg_n,
    output logic hold,
    output logic bus_oe
);
    localparam int unsigned IN_W = 2;

    logic [IN_W-1:0] raw_in, sync_out;

    assign raw_in = {bgack_n, br_n};

    busarb_sync #(
        .WIDTH   (IN_W),
        .STAGES  (ARB_SYNC_STAGES),
        .RST_VAL ({IN_W{1'b1}})
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    busarb_fsm #(
        .TWO_WIRE (TWO_WIRE)
    ) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (~sync_out[0]),
        .ack_in (~sync_out[1]),
        .busy   (busy),
        .bg_n   (bg_n),
        .hold   (hold),
        .bus_oe (bus_oe)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (bg_n && !hold && bus_oe));

endmodule

// File: tb/busarb_ctrl_tb_top.sv
`timescale 1ns/1ps
module busarb_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic br3_n = 1'b1, bgack3_n = 1'b1, busy3 = 1'b0;
    logic bg3_n, hold3, oe3;
    logic br2_n = 1'b1, bgack2_n = 1'b1, busy2 = 1'b0;
    logic bg2_n, hold2, oe2;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    busarb_ctrl #(.TWO_WIRE(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .br_n(br3_n), .bgack_n(bgack3_n), .busy(busy3),
        .bg_n(bg3_n), .hold(hold3), .bus_oe(oe3));

    busarb_ctrl #(.TWO_WIRE(1'b1)) dut_tw_i (
        .clk(clk), .rst_n(rst_n), .br_n(br2_n), .bgack_n(bgack2_n), .busy(busy2),
        .bg_n(bg2_n), .hold(hold2), .bus_oe(oe2));

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Three-wire handover: transfer ends after db cycles, acknowledge after da.
    task automatic run3(int db, int da);
        int own;
        own = imax(da + 3, db + 1);
        busy3 = (db > 0);
        br3_n = 1'b0;
        for (int c = 1; c <= own + 1; c++) begin
            tick();
            if (c == db) busy3 = 1'b0;
            if (c == da) bgack3_n = 1'b0;
            chk("R2", "hold3", hold3, (c >= 3));
            chk((c <= db) ? "R3" : "R4", "oe3", oe3, (c < own));
            chk("R4", "bg3_n", bg3_n, !(c >= 3 && c < own));
        end
        br3_n = 1'b1;
        bgack3_n = 1'b1;
        for (int c = 1; c <= 3; c++) begin
            tick();
            chk("R6", "oe3", oe3, (c == 3));
            chk("R9", "hold3", hold3, (c < 3));
            chk("R6", "bg3_n", bg3_n, 1'b1);
        end
    endtask

    // Three-wire withdrawal before any acknowledge.
    task automatic withdraw3(int w, bit with_busy);
        busy3 = with_busy;
        br3_n = 1'b0;
        for (int c = 1; c <= w + 4; c++) begin
            tick();
            if (c == w) br3_n = 1'b1;
            chk("R5", "bg3_n", bg3_n, !(c >= 3 && c < w + 3));
            chk("R5", "hold3", hold3, (c >= 3 && c < w + 3));
            chk("R5", "oe3", oe3, 1'b1);
        end
        busy3 = 1'b0;
        tick();
    endtask

    // Two-wire handover; bgack2_n is held low throughout (R7).
    task automatic run2(int db);
        int own;
        own = imax(4, db + 1);
        busy2 = (db > 0);
        br2_n = 1'b0;
        for (int c = 1; c <= own + 1; c++) begin
            tick();
            if (c == db) busy2 = 1'b0;
            chk("R2", "hold2", hold2, (c >= 3));
            chk("R8", "oe2", oe2, (c < own));
            chk("R8", "bg2_n", bg2_n, !(c >= 3 && c < own));
        end
        br2_n = 1'b1;
        for (int c = 1; c <= 3; c++) begin
            tick();
            chk("R6", "oe2", oe2, (c == 3));
            chk("R6", "hold2", hold2, (c < 3));
        end
    endtask

    task automatic withdraw2(int w);
        busy2 = 1'b1;
        br2_n = 1'b0;
        for (int c = 1; c <= w + 4; c++) begin
            tick();
            if (c == w) br2_n = 1'b1;
            chk("R8", "bg2_n", bg2_n, !(c >= 3 && c < w + 3));
            chk("R8", "hold2", hold2, (c >= 3 && c < w + 3));
            chk("R3", "oe2", oe2, 1'b1);
        end
        busy2 = 1'b0;
        tick();
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state for both variants
        chk("R1", "bg3_n", bg3_n, 1'b1);
        chk("R1", "hold3", hold3, 1'b0);
        chk("R1", "oe3", oe3, 1'b1);
        chk("R1", "bg2_n", bg2_n, 1'b1);
        chk("R1", "hold2", hold2, 1'b0);
        chk("R1", "oe2", oe2, 1'b1);
        tick();

        for (int db = 0; db <= 6; db++) begin
            for (int da = 3; da <= 5; da++) begin
                run3(db, da);
                tick();
            end
        end
        for (int w = 3; w <= 5; w++) begin
            withdraw3(w, 1'b1);
            withdraw3(w, 1'b0);
        end

        // R7: acknowledge pin alone must do nothing in two-wire mode
        bgack2_n = 1'b0;
        for (int c = 1; c <= 6; c++) begin
            tick();
            chk("R7", "bg2_n", bg2_n, 1'b1);
            chk("R7", "hold2", hold2, 1'b0);
            chk("R7", "oe2", oe2, 1'b1);
        end
        for (int db = 0; db <= 7; db++) begin
            run2(db);
            tick();
        end
        for (int w = 3; w <= 5; w++) withdraw2(w);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule